// File: doc/BRIEF.md
# MII Receive Qualification and Line Status

This block sits on the MAC-facing side of a 10/100 Ethernet transceiver. It takes the nibbles the line decoder produces on the receive clock, each with a flag saying whether the underlying symbol was legal. It also takes a receive-activity indication, the MAC's transmit enable and transmit error, a speed select and a duplex select. It produces the receive data, data-valid and receive-error signals toward the MAC, plus carrier sense, collision and a request asking the line encoder to emit the halt code group.

The receive path has a fixed two-edge latency in both speeds. At 100 Mb/s every nibble of the frame is passed through, starting with the first preamble nibble. A nibble whose symbol was illegal is replaced by an error code. At 10 Mb/s the preamble is held back. Data-valid first rises on the low nibble of the start-of-frame delimiter, which is found as a 5 nibble followed directly by a D nibble. Carrier sense, collision and the halt request are combinational.

Top module: `mii_phy_side`

## Requirements
- R1: While `rst` is high at a clock edge, `mii_rx_dv`, `mii_rx_er` and `mii_rxd` are zero after that edge, and the delimiter search returns to its hunting state.
- R2: With `speed_100` high, a nibble presented with `rx_active` high appears on `mii_rxd` with `mii_rx_dv` high two rising edges later. This applies to preamble nibbles as well.
- R3: With `speed_100` high, a nibble presented with `rx_sym_ok` low comes out two edges later with `mii_rx_er` high, `mii_rx_dv` high and `mii_rxd` equal to 4'b1110. Legal nibbles come out with `mii_rx_er` low.
- R4: With `speed_100` low, output stays invalid and zero until the first adjacent nibble pair 4'h5 then 4'hD within the frame. The 4'h5 of that pair, the 4'hD and every later nibble of the frame are forwarded with `mii_rx_dv` high, two edges after input. A 4'hD that does not directly follow a 4'h5 starts nothing.
- R5: With `speed_100` low, `rx_sym_ok` has no effect: `mii_rx_er` stays low and nibbles pass unchanged. A frame with no 5-then-D pair produces no valid output.
- R6: On the output slot after the last nibble of a frame (two edges after `rx_active` falls), `mii_rx_dv`, `mii_rx_er` and `mii_rxd` are all zero.
- R7: `mii_crs` is high whenever `rx_active` is high, in either duplex.
- R8: `tx_en` raises `mii_crs` only when `full_dup` is low. With `full_dup` high and `rx_active` low, `mii_crs` is low.
- R9: `mii_col` is high exactly when `full_dup` is low and both `tx_en` and `rx_active` are high.
- R10: `enc_halt_req` is high exactly when `tx_en` and `tx_er` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| speed_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_dup | input | 1 | 1 selects full duplex |
| rx_active | input | 1 | Line receive activity; a frame lasts while high |
| rx_nib | input | 4 | Decoded receive nibble |
| rx_sym_ok | input | 1 | Decoded symbol was legal |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| mii_rxd | output | 4 | Receive data to the MAC |
| mii_rx_dv | output | 1 | Receive data valid |
| mii_rx_er | output | 1 | Receive error |
| mii_crs | output | 1 | Carrier sense (combinational) |
| mii_col | output | 1 | Collision (combinational) |
| enc_halt_req | output | 1 | Request to send the halt code group |

## Verification
The bench checks every output slot of whole frames against a model of its own. This catches designs that are off by one cycle, forward preamble at 10 Mb/s, or drop the 5 of the delimiter pair. At 10 Mb/s the bench sends a stray D that follows a non-5 nibble; a matcher looking only for D would open the frame too early. It also sends a frame with no delimiter and illegal symbols; leaking the error flag into 10 Mb/s mode would then show up as a spurious receive error. At 100 Mb/s, illegal symbols at the first and last positions and single-nibble frames test the error code and the drop of data-valid. All sixteen combinations of the status inputs are swept, which exposes carrier sense on transmit in full duplex and collision in full duplex.

// File: rtl/mii_side_pkg.sv
package mii_side_pkg;

  localparam int NIB_W = 4;

  typedef struct packed {
    logic             act;
    logic             ok;
    logic [NIB_W-1:0] nib;
  } rx_slot_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_PASS = 1'b1
  } strip_st_e;

  function automatic logic carrier_fn(input logic rx_act, input logic tx_act,
                                      input logic fdx);
    return rx_act | (tx_act & ~fdx);
  endfunction

  function automatic logic collide_fn(input logic rx_act, input logic tx_act,
                                      input logic fdx);
    return rx_act & tx_act & ~fdx;
  endfunction

  function automatic logic halt_fn(input logic tx_act, input logic tx_bad);
    return tx_act & tx_bad;
  endfunction

endpackage

// File: rtl/mii_rx_capture.sv
module mii_rx_capture
  import mii_side_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rx_slot_t live,
  output rx_slot_t held
);
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= live;
  end
endmodule

// File: rtl/mii_rx_strip.sv
module mii_rx_strip
  import mii_side_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     slow_mode,
  input  rx_slot_t held,
  input  rx_slot_t live,
  output logic     sfd_hit,
  output logic     fwd
);
  strip_st_e st_q, st_d;

  always_comb begin
    sfd_hit = slow_mode && (st_q == ST_HUNT) && held.act && live.act &&
              (held.nib == PRE_NIB) && (live.nib == SFD_NIB);
    fwd     = slow_mode && (sfd_hit || ((st_q == ST_PASS) && held.act));
    st_d    = st_q;
    if (!slow_mode || !held.act) st_d = ST_HUNT;
    else if (sfd_hit)            st_d = ST_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_HUNT;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/mii_rx_out.sv
module mii_rx_out
  import mii_side_pkg::*;
#(
  parameter logic [NIB_W-1:0] ERR_NIB = 4'hE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_mode,
  input  rx_slot_t         held,
  input  logic             fwd,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er
);
  logic             dv_d, er_d;
  logic [NIB_W-1:0] rxd_d;

  always_comb begin
    dv_d  = fast_mode ? held.act : fwd;
    er_d  = fast_mode && held.act && !held.ok;
    rxd_d = '0;
    if (dv_d) rxd_d = er_d ? ERR_NIB : held.nib;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd   <= '0;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
    end else begin
      rxd   <= rxd_d;
      rx_dv <= dv_d;
      rx_er <= er_d;
    end
  end
endmodule

// File: rtl/mii_line_status.sv
module mii_line_status
  import mii_side_pkg::*;
(
  input  logic rx_act,
  input  logic tx_act,
  input  logic tx_bad,
  input  logic fdx,
  output logic crs,
  output logic col,
  output logic halt
);
  always_comb begin
    crs  = carrier_fn(rx_act, tx_act, fdx);
    col  = collide_fn(rx_act, tx_act, fdx);
    halt = halt_fn(tx_act, tx_bad);
  end
endmodule

// File: rtl/mii_phy_side.sv
module mii_phy_side
  import mii_side_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD,
  parameter logic [NIB_W-1:0] ERR_NIB = 4'hE,
  parameter bit               HAS_10M = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             speed_100,
  input  logic             full_dup,
  input  logic             rx_active,
  input  logic [NIB_W-1:0] rx_nib,
  input  logic             rx_sym_ok,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic [NIB_W-1:0] mii_rxd,
  output logic             mii_rx_dv,
  output logic             mii_rx_er,
  output logic             mii_crs,
  output logic             mii_col,
  output logic             enc_halt_req
);
  rx_slot_t live, held;
  logic     held_act, held_ok;
  logic     sfd_hit, fwd;

  assign live.act = rx_active;
  assign live.ok  = rx_sym_ok;
  assign live.nib = rx_active ? rx_nib : '0;
  assign held_act = held.act;
  assign held_ok  = held.ok;

  mii_rx_capture u_cap (.clk(clk), .rst(rst), .live(live), .held(held));

  generate
    if (HAS_10M) begin : g_strip
      mii_rx_strip #(.PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_strip (
        .clk(clk), .rst(rst), .slow_mode(!speed_100),
        .held(held), .live(live), .sfd_hit(sfd_hit), .fwd(fwd));
    end else begin : g_nostrip
      assign sfd_hit = 1'b0;
      assign fwd     = 1'b0;
    end
  endgenerate

  mii_rx_out #(.ERR_NIB(ERR_NIB)) u_out (
    .clk(clk), .rst(rst), .fast_mode(speed_100), .held(held), .fwd(fwd),
    .rxd(mii_rxd), .rx_dv(mii_rx_dv), .rx_er(mii_rx_er));

  mii_line_status u_stat (
    .rx_act(rx_active), .tx_act(tx_en), .tx_bad(tx_er), .fdx(full_dup),
    .crs(mii_crs), .col(mii_col), .halt(enc_halt_req));
endmodule

// File: rtl/mii_phy_side_chk.sv
module mii_phy_side_chk #(
  parameter logic [3:0] PRE_NIB = 4'h5,
  parameter logic [3:0] ERR_NIB = 4'hE
) (
  input logic       clk,
  input logic       rst,
  input logic       speed_100,
  input logic       full_dup,
  input logic       rx_active,
  input logic       tx_en,
  input logic       tx_er,
  input logic       held_act,
  input logic       held_ok,
  input logic       sfd_hit,
  input logic [3:0] mii_rxd,
  input logic       mii_rx_dv,
  input logic       mii_rx_er,
  input logic       mii_crs,
  input logic       mii_col,
  input logic       enc_halt_req
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!mii_rx_dv && !mii_rx_er && mii_rxd == 4'h0));

  assert_fast_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (speed_100 && held_act) |=> mii_rx_dv);

  assert_err_code_R3: assert property (@(posedge clk) disable iff (rst)
    (speed_100 && held_act && !held_ok) |=> (mii_rx_er && mii_rx_dv && mii_rxd == ERR_NIB));

  assert_sfd_start_R4: assert property (@(posedge clk) disable iff (rst)
    (!speed_100 && !mii_rx_dv) |=> (!mii_rx_dv || mii_rxd == PRE_NIB));

  assert_sfd_needs_rx_R4: assert property (@(posedge clk) disable iff (rst)
    sfd_hit |-> (rx_active && !speed_100));

  assert_slow_no_err_R5: assert property (@(posedge clk) disable iff (rst)
    !speed_100 |=> !mii_rx_er);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !held_act |=> (!mii_rx_dv && !mii_rx_er && mii_rxd == 4'h0));

  assert_rx_crs_R7: assert property (@(posedge clk) disable iff (rst)
    rx_active |-> mii_crs);

  assert_fdx_tx_crs_R8: assert property (@(posedge clk) disable iff (rst)
    (full_dup && !rx_active) |-> !mii_crs);

  assert_col_half_R9: assert property (@(posedge clk) disable iff (rst)
    mii_col |-> (mii_crs && !full_dup && tx_en));

  assert_halt_R10: assert property (@(posedge clk) disable iff (rst)
    enc_halt_req |-> (tx_er && tx_en));
endmodule

bind mii_phy_side mii_phy_side_chk #(.PRE_NIB(PRE_NIB), .ERR_NIB(ERR_NIB)) u_chk (
  .clk(clk), .rst(rst), .speed_100(speed_100), .full_dup(full_dup),
  .rx_active(rx_active), .tx_en(tx_en), .tx_er(tx_er),
  .held_act(held_act), .held_ok(held_ok), .sfd_hit(sfd_hit),
  .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er),
  .mii_crs(mii_crs), .mii_col(mii_col), .enc_halt_req(enc_halt_req));

// File: tb/mii_phy_side_bench.sv
module mii_phy_side_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_100 = 1'b1;
  logic       full_dup = 1'b0;
  logic       rx_active = 1'b0;
  logic [3:0] rx_nib = 4'h0;
  logic       rx_sym_ok = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] mii_rxd;
  logic       mii_rx_dv, mii_rx_er, mii_crs, mii_col, enc_halt_req;

  int total = 0;
  int bad = 0;

  logic [3:0] fr_nib [32];
  logic       fr_ok  [32];

  always #5 clk = ~clk;

  mii_phy_side u_mii_phy_side (
    .clk(clk), .rst(rst), .speed_100(speed_100), .full_dup(full_dup),
    .rx_active(rx_active), .rx_nib(rx_nib), .rx_sym_ok(rx_sym_ok),
    .tx_en(tx_en), .tx_er(tx_er), .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv),
    .mii_rx_er(mii_rx_er), .mii_crs(mii_crs), .mii_col(mii_col),
    .enc_halt_req(enc_halt_req));

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got dv/er/rxd=%b expected %b", req, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [3:0] v, input logic ok);
    fr_nib[i] = v;
    fr_ok[i]  = ok;
  endtask

  task automatic fill_std(input int start);
    for (int i = 0; i < 4; i++) put(start + i, 4'h5, 1'b1);
    put(start + 4, 4'h5, 1'b1);
    put(start + 5, 4'hD, 1'b1);
    put(start + 6, 4'h1, 1'b1);
    put(start + 7, 4'h2, 1'b1);
    put(start + 8, 4'hA, 1'b1);
    put(start + 9, 4'hF, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_active = 1'b0; rx_nib = 4'h0; rx_sym_ok = 1'b1;
    end
  endtask

  // Sends fr_nib[0..len-1] and compares every output slot with the model.
  task automatic run_frame(input logic spd, input string req, input int len);
    logic [5:0] obs [40];
    logic [5:0] e;
    int k;
    int j;
    @(negedge clk);
    speed_100 = spd;
    k = -1;
    for (int i = 0; i + 1 < len; i++)
      if (k < 0 && fr_nib[i] == 4'h5 && fr_nib[i+1] == 4'hD) k = i;
    for (int i = 0; i < len + 3; i++) begin
      @(negedge clk);
      obs[i] = {mii_rx_dv, mii_rx_er, mii_rxd};
      if (i < len) begin
        rx_active = 1'b1; rx_nib = fr_nib[i]; rx_sym_ok = fr_ok[i];
      end else begin
        rx_active = 1'b0; rx_nib = 4'h0; rx_sym_ok = 1'b1;
      end
    end
    for (int i = 0; i < len + 3; i++) begin
      j = i - 2;
      e = 6'b0;
      if (j >= 0 && j < len) begin
        if (spd) e = fr_ok[j] ? {2'b10, fr_nib[j]} : {2'b11, 4'hE};
        else if (k >= 0 && j >= k) e = {2'b10, fr_nib[j]};
      end
      if (j >= len) chk("R6 idle after frame", obs[i], e);
      else          chk(req, obs[i], e);
    end
    idle(2);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1; speed_100 = 1'b1; rx_active = 1'b1; rx_nib = 4'h7;
    @(negedge clk);
    @(negedge clk);
    chk("R1 outputs cleared in reset", {mii_rx_dv, mii_rx_er, mii_rxd}, 6'b0);
    rst = 1'b0; rx_active = 1'b0;
    idle(3);
    // enter pass state at 10 Mb/s, then reset mid-frame
    speed_100 = 1'b0;
    @(negedge clk); rx_active = 1'b1; rx_nib = 4'h5;
    @(negedge clk); rx_nib = 4'hD;
    @(negedge clk); rx_nib = 4'h3; rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-frame", {mii_rx_dv, mii_rx_er, mii_rxd}, 6'b0);
    rst = 1'b0; rx_nib = 4'h4;
    @(negedge clk); rx_nib = 4'h6;
    @(negedge clk); rx_nib = 4'h8;
    chk("R1 hunting after reset", {mii_rx_dv, mii_rx_er, mii_rxd}, 6'b0);
    idle(3);
  endtask

  task automatic test_fast_clean();
    fill_std(0);
    run_frame(1'b1, "R2 100M pass-through", 10);
  endtask

  task automatic test_fast_err();
    fill_std(0);
    put(0, 4'h5, 1'b0);
    put(7, 4'h2, 1'b0);
    put(9, 4'hF, 1'b0);
    run_frame(1'b1, "R3 100M invalid symbol", 10);
  endtask

  task automatic test_slow_clean();
    fill_std(0);
    run_frame(1'b0, "R4 10M preamble stripped", 10);
  endtask

  task automatic test_slow_stray();
    put(0, 4'h5, 1'b1); put(1, 4'h5, 1'b1); put(2, 4'hA, 1'b1);
    put(3, 4'hD, 1'b0); put(4, 4'h5, 1'b1); put(5, 4'h5, 1'b1);
    put(6, 4'hD, 1'b1); put(7, 4'h9, 1'b0); put(8, 4'h5, 1'b1);
    put(9, 4'hD, 1'b1); put(10, 4'h0, 1'b0);
    run_frame(1'b0, "R4 R5 stray D and ignored symbol flag", 11);
  endtask

  task automatic test_slow_nosfd();
    for (int i = 0; i < 6; i++) put(i, 4'h5, (i % 2) == 0);
    put(6, 4'h3, 1'b0); put(7, 4'hD, 1'b0);
    run_frame(1'b0, "R5 no delimiter no output", 8);
  endtask

  task automatic test_short();
    put(0, 4'hC, 1'b1);
    run_frame(1'b1, "R6 single nibble frame", 1);
    put(0, 4'h5, 1'b0);
    run_frame(1'b1, "R3 R6 single bad nibble", 1);
  endtask

  task automatic test_line();
    logic [3:0] v;
    logic ec, el, eh;
    for (int c = 0; c < 16; c++) begin
      v = c[3:0];
      @(negedge clk);
      rx_active = v[0]; tx_en = v[1]; full_dup = v[2]; tx_er = v[3];
      #1;
      ec = v[0] || (v[1] && !v[2]);
      el = !v[2] && v[1] && v[0];
      eh = v[1] && v[3];
      if (v[0]) chk("R7 crs on receive", {5'b0, mii_crs}, {5'b0, ec});
      else      chk("R8 crs on transmit", {5'b0, mii_crs}, {5'b0, ec});
      chk("R9 collision", {5'b0, mii_col}, {5'b0, el});
      chk("R10 halt request", {5'b0, enc_halt_req}, {5'b0, eh});
    end
    @(negedge clk);
    rx_active = 1'b0; tx_en = 1'b0; tx_er = 1'b0; full_dup = 1'b0;
    idle(3);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_fast_clean();
    test_fast_err();
    test_slow_clean();
    test_slow_stray();
    test_slow_nosfd();
    test_short();
    test_line();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule